// File: doc/BRIEF.md
# Memory Pattern Self-Test Controller

This block tests a synchronous single-port RAM by itself, with no software involved. After a start pulse it drives the RAM's address, write-data and write-enable pins through a fixed schedule. First comes a short pass that checks the address lines. Then come three data phases: a checkerboard, its complement, and a walking-ones pattern. Every phase writes all of its locations first and then reads each one back in the same order. The value the RAM returns one cycle after each read address is compared with the value that phase should have left there.

The first compare that disagrees raises a sticky fail flag. It also records the failing address and the code of the phase that found it. The run does not stop at that point: it always runs to the end of the schedule, then drops busy and holds done until the next start. A designer gets a pass/fail verdict, plus the first location and pattern that broke. All widths are parameters, so one controller serves RAMs of any size.

Top module: `ram_pattern_bist`

## Requirements
- R1: While reset is held and after it is released, busy, done and fail are 0, fail_addr is 0 and fail_phase is 0.
- R2: A start pulse seen while the controller is idle or done makes busy 1 and done 0 on the next cycle. Busy then stays 1 for exactly 2*(ADDR_W+1) + 6*2^ADDR_W + 1 cycles. After that busy is 0 and done is 1, and done stays 1 until the next accepted start.
- R3: The first pass writes the value k+1 to address 0 for k=0 and to address 2^(k-1) for k=1..ADDR_W, in increasing k. It then reads the same addresses in the same order. Its phase code is 1.
- R4: The second pass writes every address from 0 upward. Bit i of the word at address a is 1 exactly when i+a is odd. It then reads every address from 0 upward. Its phase code is 2.
- R5: The third pass has the same order as R4 but writes the bitwise complement of the R4 word. Its phase code is 3.
- R6: The fourth pass has the same order as R4. The word at address a has only bit (a mod DATA_W) set. Its phase code is 4.
- R7: For each read, the RAM data present one cycle after the address is compared with that pass's expected word, and any difference counts as a mismatch.
- R8: The first mismatch of a run sets fail and latches its address and phase code. Later mismatches change none of these, and the run still lasts the full length of R2.
- R9: A start pulse while busy is 1 has no effect on the schedule or its length.
- R10: An accepted start clears fail, fail_addr (to 0), fail_phase (to 0) and done.
- R11: mem_we is 1 only during the write half of a pass, never while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test run (taken only when idle or done) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| fail | output | 1 | A mismatch was seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_phase | output | 3 | Phase code of the first mismatch (1..4, 0 if none) |

## Verification
The bench drives every address with stuck-at-0 and stuck-at-1 faults on two bit positions. It predicts the phase that must catch each fault: a pattern generator with a wrong bit polarity or ordering would report the wrong phase or miss the fault. Each address line is also shorted in turn. A design that skipped the address pass, or read before writing all of its locations, would blame a data phase or a nonzero address instead of phase 1 at address 0. Faults armed only for the walking phase, including one at the very last address, catch a controller that drops the final compare or ignores the one-cycle read latency. Mid-run start pulses and back-to-back runs expose a controller that restarts while busy or forgets to clear the previous verdict.

// File: rtl/rpb_pkg.sv
`timescale 1ns/1ps
package rpb_pkg;

    // Phase codes reported on fail_phase; the order is the run order.
    typedef enum logic [2:0] {
        PH_NONE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_CHECK  = 3'd2,
        PH_INVERT = 3'd3,
        PH_WALK   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    // Control for the operation presented to the RAM this cycle.
    typedef struct packed {
        logic   active;
        logic   write;
        phase_e phase;
    } op_ctl_t;

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_ADDR:   return PH_CHECK;
            PH_CHECK:  return PH_INVERT;
            PH_INVERT: return PH_WALK;
            default:   return PH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rpb_seq.sv
`timescale 1ns/1ps
module rpb_seq import rpb_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output op_ctl_t           ctl,
    output logic [ADDR_W-1:0] idx,
    output logic              launch,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ABUS_LAST = ADDR_W'(ADDR_W);
    localparam logic [ADDR_W-1:0] FULL_LAST = '1;

    state_e            state_q;
    phase_e            phase_q;
    logic              rd_q;
    logic [ADDR_W-1:0] idx_q;
    logic              last;

    assign last   = idx_q == ((phase_q == PH_ADDR) ? ABUS_LAST : FULL_LAST);
    assign launch = start && (state_q == ST_IDLE || state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_NONE;
            rd_q    <= 1'b0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        phase_q <= PH_ADDR;
                        rd_q    <= 1'b0;
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        idx_q <= '0;
                        if (!rd_q) begin
                            rd_q <= 1'b1;
                        end else begin
                            rd_q <= 1'b0;
                            if (phase_q == PH_WALK) begin
                                state_q <= ST_FLUSH;
                                phase_q <= PH_NONE;
                            end else begin
                                phase_q <= phase_after(phase_q);
                            end
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FLUSH: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl.active = state_q == ST_RUN;
    assign ctl.write  = (state_q == ST_RUN) && !rd_q;
    assign ctl.phase  = phase_q;
    assign idx        = idx_q;
    assign busy       = state_q == ST_RUN || state_q == ST_FLUSH;
    assign done       = state_q == ST_DONE;

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy && !done);                                          // R2
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);                                           // R2
    AST_DONE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state_q) == ST_FLUSH);                        // R2
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && start) |=>
            !(state_q == ST_RUN && phase_q == PH_ADDR && !rd_q && idx_q == '0)); // R9

endmodule

// File: rtl/rpb_patgen.sv
`timescale 1ns/1ps
module rpb_patgen import rpb_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] idx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] chk;
    logic [DATA_W-1:0] walk;
    logic [DATA_W-1:0] tag;

    // Address-line pass visits 0, then each single-bit address.
    assign addr = (phase != PH_ADDR) ? idx :
                  (idx == '0)        ? '0  : (ADDR_W'(1) << (idx - 1'b1));

    // Bit b of the checkerboard word is set when b + address is odd.
    for (genvar b = 0; b < DATA_W; b++) begin : g_chk
        assign chk[b] = addr[0] ^ ((b % 2) == 1);
    end

    assign walk = DATA_W'(1) << (addr % DATA_W);
    assign tag  = DATA_W'(idx) + DATA_W'(1);

    always_comb begin
        case (phase)
            PH_ADDR:   data = tag;
            PH_CHECK:  data = chk;
            PH_INVERT: data = ~chk;
            PH_WALK:   data = walk;
            default:   data = '0;
        endcase
    end

endmodule

// File: rtl/rpb_cmp.sv
`timescale 1ns/1ps
module rpb_cmp import rpb_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  op_ctl_t           ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] expect_data,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output phase_e            fail_phase
);
    // One stage of expected data travels with each read to meet the RAM output.
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_exp_q;
    phase_e            pend_phase_q;
    logic              mismatch;

    logic              fail_q;
    logic [ADDR_W-1:0] fail_addr_q;
    phase_e            fail_phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            pend_addr_q  <= '0;
            pend_exp_q   <= '0;
            pend_phase_q <= PH_NONE;
        end else begin
            pend_q       <= ctl.active && !ctl.write;
            pend_addr_q  <= addr;
            pend_exp_q   <= expect_data;
            pend_phase_q <= ctl.phase;
        end
    end

    assign mismatch = pend_q && (rdata != pend_exp_q);

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            fail_q       <= 1'b0;
            fail_addr_q  <= '0;
            fail_phase_q <= PH_NONE;
        end else if (mismatch && !fail_q) begin
            fail_q       <= 1'b1;
            fail_addr_q  <= pend_addr_q;
            fail_phase_q <= pend_phase_q;
        end
    end

    assign fail       = fail_q;
    assign fail_addr  = fail_addr_q;
    assign fail_phase = fail_phase_q;

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        mismatch && !launch |=> fail_q);                                    // R7
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fail_q && !launch |=> fail_q);                                      // R8
    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
        fail_q && !launch |=> $stable(fail_addr_q) && $stable(fail_phase_q)); // R8
    AST_FAIL_HAS_PHASE: assert property (@(posedge clk) disable iff (rst)
        fail_q |-> fail_phase_q != PH_NONE);                                // R8
    AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        launch |=> !fail_q && fail_phase_q == PH_NONE && fail_addr_q == '0); // R10

endmodule

// File: rtl/ram_pattern_bist.sv
`timescale 1ns/1ps
module ram_pattern_bist import rpb_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_phase
);
    op_ctl_t           ctl;
    logic [ADDR_W-1:0] idx;
    logic              launch;
    logic [ADDR_W-1:0] gen_addr;
    logic [DATA_W-1:0] gen_data;
    phase_e            fail_phase_e;

    rpb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ctl    (ctl),
        .idx    (idx),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    rpb_patgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
        .phase (ctl.phase),
        .idx   (idx),
        .addr  (gen_addr),
        .data  (gen_data)
    );

    rpb_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .ctl         (ctl),
        .addr        (gen_addr),
        .expect_data (gen_data),
        .rdata       (mem_rdata),
        .fail        (fail),
        .fail_addr   (fail_addr),
        .fail_phase  (fail_phase_e)
    );

    assign mem_addr   = gen_addr;
    assign mem_wdata  = gen_data;
    assign mem_we     = ctl.write;
    assign fail_phase = fail_phase_e;

    AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);                                                   // R11
    AST_WALK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (mem_we && ctl.phase == PH_WALK) |-> $onehot(mem_wdata));           // R6
    AST_NO_WE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);                                                  // R11

endmodule

// File: tb/ram_pattern_bist_test.sv
`timescale 1ns/1ps
module ram_pattern_bist_test;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NA    = AW + 1;
    localparam int NOPS  = 2 * NA + 6 * DEPTH;
    localparam int WALK0 = 2 * NA + 4 * DEPTH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [2:0]    fail_phase;

    always #2.5 clk = ~clk;

    ram_pattern_bist #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_phase(fail_phase)
    );

    int checks = 0;
    int failures = 0;

    // RAM model with optional address-line short and read-side stuck bit.
    logic [DW-1:0] mem [DEPTH];
    int   alias_bit = -1;
    int   flt_addr  = -1;
    int   flt_bit   = 0;
    int   flt_from  = 0;
    logic flt_val   = 1'b0;
    int   cur_op = 0, busy_cycles = 0, str_err = 0;

    function automatic logic [AW-1:0] eff(logic [AW-1:0] a);
        if (alias_bit >= 0) return a & ~(AW'(1) << alias_bit);
        return a;
    endfunction

    always @(posedge clk) begin
        logic [DW-1:0] v;
        if (mem_we) mem[eff(mem_addr)] <= mem_wdata;
        v = mem[eff(mem_addr)];
        if (flt_addr == int'(mem_addr) && cur_op >= flt_from) v[flt_bit] = flt_val;
        mem_rdata <= v;
    end

    function automatic logic [DW-1:0] chk_word(int a);
        logic [DW-1:0] w;
        for (int b = 0; b < DW; b++) w[b] = ((a + b) % 2) == 1;
        return w;
    endfunction

    function automatic logic [DW-1:0] walk_word(int a);
        logic [DW-1:0] w;
        w = '0;
        w[a % DW] = 1'b1;
        return w;
    endfunction

    function automatic int abus_addr(int k);
        return (k == 0) ? 0 : (1 << (k - 1));
    endfunction

    function automatic void exp_op(int j, output logic we, output int a, output logic [DW-1:0] d);
        int r, p;
        d = '0;
        if (j < NA) begin
            we = 1'b1; a = abus_addr(j); d = DW'(j + 1);
        end else if (j < 2 * NA) begin
            we = 1'b0; a = abus_addr(j - NA);
        end else begin
            r = (j - 2 * NA) % (2 * DEPTH);
            p = (j - 2 * NA) / (2 * DEPTH);
            we = r < DEPTH;
            a = r % DEPTH;
            case (p)
                0:       d = chk_word(a);
                1:       d = ~chk_word(a);
                default: d = walk_word(a);
            endcase
        end
    endfunction

    // Phase that must first catch a read-side stuck bit (armed from time zero).
    function automatic int stuck_phase(int x, int b, logic v);
        logic [DW-1:0] t;
        for (int k = 0; k <= AW; k++) begin
            if (abus_addr(k) == x) begin
                t = DW'(k + 1);
                if (t[b] != v) return 1;
            end
        end
        t = chk_word(x);
        if (t[b] != v) return 2;
        return 3;
    endfunction

    // Stream monitor: operation j is presented in the j-th busy cycle (R3..R6, R11).
    always @(negedge clk) begin
        logic we_e;
        int a_e;
        logic [DW-1:0] d_e;
        if (busy) begin
            cur_op = busy_cycles;
            busy_cycles++;
            if (cur_op < NOPS) begin
                exp_op(cur_op, we_e, a_e, d_e);
                if (mem_we !== we_e || int'(mem_addr) != a_e || (we_e && mem_wdata !== d_e)) begin
                    if (str_err == 0)
                        $display("stream diff op %0d: we=%0b addr=%0d data=%h exp we=%0b addr=%0d data=%h",
                                 cur_op, mem_we, mem_addr, mem_wdata, we_e, a_e, d_e);
                    str_err++;
                end
            end else if (mem_we) begin
                str_err++;
            end
        end else if (mem_we) begin
            str_err++;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int l_done, l_busy, l_fail;

    task automatic run_once(int poke);
        busy_cycles = 0;
        str_err = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        l_done = done; l_busy = busy; l_fail = fail;
        for (int i = 0; i < NOPS + 20 && !done; i++) begin
            @(negedge clk);
            if (i == poke || i == poke + 1) start = (i == poke);
        end
        start = 1'b0;
    endtask

    task automatic check_end(string tag, int exp_fail, int exp_addr, int exp_ph);
        check({tag, " R2 done"}, done, 1);
        check({tag, " R2 busy low"}, busy, 0);
        check({tag, " R2 R8 run length"}, busy_cycles, NOPS + 1);
        check({tag, " R3 R4 R5 R6 R11 stream"}, str_err, 0);
        check({tag, " R10 launch clears"}, l_done * 4 + l_busy * 2 + l_fail, 2);
        check({tag, " R7 R8 fail"}, fail, exp_fail);
        if (exp_fail != 0) begin
            check({tag, " R8 fail_addr"}, fail_addr, exp_addr);
            check({tag, " R8 fail_phase"}, fail_phase, exp_ph);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 fail", fail, 0);
        check("R1 fail_addr", fail_addr, 0);
        check("R1 fail_phase", fail_phase, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {busy, done, fail, mem_we}, 0);

        // Clean run
        run_once(-1);
        check_end("clean", 0, 0, 0);
        repeat (10) @(negedge clk);
        check("R2 done held", done, 1);

        // R9: start pulses in mid-run are ignored
        run_once(50);
        check_end("R9 mid-start", 0, 0, 0);
        run_once(NOPS - 1);
        check_end("R9 flush-start", 0, 0, 0);

        // Stuck-bit sweep over all addresses, two bits, both polarities
        flt_from = 0;
        for (int x = 0; x < DEPTH; x++) begin
            for (int s = 0; s < 2; s++) begin
                for (int v = 0; v < 2; v++) begin
                    flt_addr = x;
                    flt_bit  = (s == 0) ? (x % DW) : ((x + 3) % DW);
                    flt_val  = v[0];
                    run_once(-1);
                    check_end("R7 R8 stuck", 1, x, stuck_phase(x, flt_bit, flt_val));
                end
            end
        end

        // R6: faults armed only for the walking phase
        flt_from = WALK0;
        flt_addr = 9; flt_bit = 3; flt_val = 1'b1;
        run_once(-1);
        check_end("R6 walk mid", 1, 9, 4);
        flt_addr = DEPTH - 1; flt_bit = (DEPTH - 1) % DW; flt_val = 1'b0;
        run_once(-1);
        check_end("R6 R7 walk last", 1, DEPTH - 1, 4);
        flt_addr = -1;
        flt_from = 0;

        // R3: each shorted address line shows up at address 0 in phase 1
        for (int m = 0; m < AW; m++) begin
            alias_bit = m;
            run_once(-1);
            check_end("R3 alias", 1, 0, 1);
        end
        alias_bit = -1;

        // R10: a fresh run after failures reports clean
        run_once(-1);
        check_end("R10 clean again", 0, 0, 0);
        check("R10 fail_addr cleared", fail_addr, 0);
        check("R10 fail_phase cleared", fail_phase, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule